// File: doc/BRIEF.md
# DRAM ECC Error Status and Log

This block sits beside a memory read path and records the ECC error events that path reports. It keeps two sticky status flags, one for correctable single-bit errors and one for uncorrectable multi-bit errors. It also keeps a log of the failing column, row, bank, rank and syndrome. Rules decide when the log may be rewritten: a multi-bit entry is never displaced, and a single-bit entry is displaced only by a multi-bit one.

Software reads and clears the flags through a small register port. The same port programs a per-flag enable mask and a global system-error enable. When a flag goes from clear to set while both its enable bit and the global enable are 1, the block raises a system-error message request for one cycle.

Event input rules: the event stream uses valid/ready with `ev_ready` held high, so the block never applies back-pressure. An event is taken in every cycle where `ev_valid` is 1. The source must not expect events to be queued or merged.

The flags and the log are reset only by the power-good reset `pwrok_n`. The ordinary reset `rst_n` clears only the command registers and the message output. `rst_n` must be held low whenever `pwrok_n` is low.

Top module: `ecc_err_status`

## Requirements
- R1: The status register at address 0 reads bit 1 as the multi-bit flag and bit 0 as the single-bit flag. An accepted event sets the flag of its type (`ev_multi`=1 means multi-bit), and the flag is visible one cycle after the event.
- R2: A write to address 0 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 untouched.
- R3: Flags and log are cleared to 0 by `pwrok_n` low and keep their values through `rst_n` low.
- R4: A set flag stays set until a write-1-to-clear to it.
- R5: When a clear and a new event for the same flag fall in the same cycle, the flag stays set.
- R6: A single-bit event writes the log when neither flag is set. The log reads back at these addresses:
  - address 3: column
  - address 4: row
  - address 5: bank in bits [2:0], rank in bits [4:3]
  - address 6: syndrome
- R7: A single-bit event arriving while the single-bit flag is set and the multi-bit flag is clear sets nothing new and leaves the log unchanged.
- R8: A multi-bit event arriving while the multi-bit flag is clear overwrites the log, even when the single-bit flag is set, and sets the multi-bit flag.
- R9: While the multi-bit flag is set, no event changes the log. A single-bit event still sets the single-bit flag.
- R10: `serr_o` pulses high for exactly one cycle, in the first cycle a flag reads set, when that flag rose while its enable bit is 1 and the global enable is 1. The enable bits are at address 1 (bit 1 multi, bit 0 single) and the global enable is address 2 bit 0.
- R11: No pulse is produced while the global enable or the flag's enable bit is 0, nor while a flag stays set.
- R12: `ev_ready` is always 1, and an event is taken in every cycle `ev_valid` is 1, including back-to-back cycles.
- R13: The command registers at addresses 1 and 2 read 0 after `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary reset, active low; command registers and message output |
| pwrok_n | input | 1 | Power-good reset, active low; flags and log |
| ev_valid | input | 1 | Error event present |
| ev_ready | output | 1 | Always 1; events are never stalled |
| ev_multi | input | 1 | 1 = uncorrectable multi-bit, 0 = corrected single-bit |
| ev_col | input | COL_W | Failing column |
| ev_row | input | ROW_W | Failing row |
| ev_bank | input | BANK_W | Failing bank |
| ev_rank | input | RANK_W | Failing rank |
| ev_synd | input | SYN_W | Error syndrome |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| serr_o | output | 1 | One-cycle system-error message request |

## Verification
The main function is tried with three event patterns.
- Isolated single-bit events, then a single-bit event followed by further single-bit events. These separate the unlocked capture from the single-bit lock.
- Multi-bit events arriving over a pending single-bit entry and over a pending multi-bit entry. These show that a multi-bit overwrite happens only once.
- Writes of 0, of one bit, and of a clear in the same cycle as an event. These separate write-1-to-clear from write-to-set and show the event winning.

A long pseudo-random stream of back-to-back events, clears and enable changes is then compared every cycle against a behavioural model. This catches ordering faults between the lock decision and the clear. Two reset scenes separate ordinary reset from power-good reset.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [2:0] {
    A_STAT = 3'd0,
    A_ECMD = 3'd1,
    A_GCMD = 3'd2,
    A_LCOL = 3'd3,
    A_LROW = 3'd4,
    A_LBR  = 3'd5,
    A_LSYN = 3'd6
  } reg_addr_e;

  localparam int FLAG_SBE  = 0;
  localparam int FLAG_MBE  = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/ecc_err_flags.sv
module ecc_err_flags #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          pwrok_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o,
  output logic [NF-1:0] rise_o
);
  logic [NF-1:0] flag_q;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge pwrok_n) begin
      if (!pwrok_n)       flag_q[g] <= 1'b0;
      else if (set_i[g])  flag_q[g] <= 1'b1;
      else if (clr_i[g])  flag_q[g] <= 1'b0;
    end

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!pwrok_n)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!pwrok_n)
      set_i[g] |=> flag_q[g]);
    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!pwrok_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
  end

  assign flag_o = flag_q;
  assign rise_o = set_i & ~flag_q;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int COL_W  = 10,
  parameter int ROW_W  = 16,
  parameter int BANK_W = 3,
  parameter int RANK_W = 2,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              pwrok_n,
  input  logic              ev_fire,
  input  logic              ev_multi,
  input  logic [COL_W-1:0]  ev_col,
  input  logic [ROW_W-1:0]  ev_row,
  input  logic [BANK_W-1:0] ev_bank,
  input  logic [RANK_W-1:0] ev_rank,
  input  logic [SYN_W-1:0]  ev_synd,
  input  logic              sflag_i,
  input  logic              mflag_i,
  output logic [COL_W-1:0]  log_col,
  output logic [ROW_W-1:0]  log_row,
  output logic [BANK_W-1:0] log_bank,
  output logic [RANK_W-1:0] log_rank,
  output logic [SYN_W-1:0]  log_synd
);
  localparam int LOG_W = COL_W + ROW_W + BANK_W + RANK_W + SYN_W;

  logic [LOG_W-1:0] log_q;
  logic             capture;

  // Lock decision uses the flags as they stood before this cycle.
  assign capture = ev_fire && !mflag_i && (ev_multi || !sflag_i);

  always_ff @(posedge clk or negedge pwrok_n) begin
    if (!pwrok_n)     log_q <= '0;
    else if (capture) log_q <= {ev_col, ev_row, ev_bank, ev_rank, ev_synd};
  end

  assign {log_col, log_row, log_bank, log_rank, log_synd} = log_q;

  // R9
  mbe_freeze_chk: assert property (@(posedge clk) disable iff (!pwrok_n)
    mflag_i |=> $stable(log_q));
  // R7
  sbe_lock_chk: assert property (@(posedge clk) disable iff (!pwrok_n)
    (sflag_i && !(ev_fire && ev_multi)) |=> $stable(log_q));
  // R8
  mbe_overwrite_chk: assert property (@(posedge clk) disable iff (!pwrok_n)
    (ev_fire && ev_multi && !mflag_i) |=> (log_synd == $past(ev_synd) && log_row == $past(ev_row)));
endmodule

// File: rtl/ecc_serr_gen.sv
module ecc_serr_gen #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ecmd,
  input  logic          wr_gcmd,
  input  logic [NF-1:0] en_wdata,
  input  logic          glob_wdata,
  input  logic [NF-1:0] rise_i,
  output logic [NF-1:0] en_o,
  output logic          glob_o,
  output logic          serr_o
);
  logic [NF-1:0] en_q;
  logic          glob_q;
  logic          serr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      glob_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      if (wr_ecmd) en_q   <= en_wdata;
      if (wr_gcmd) glob_q <= glob_wdata;
      serr_q <= glob_q && |(rise_i & en_q);
    end
  end

  assign en_o   = en_q;
  assign glob_o = glob_q;
  assign serr_o = serr_q;

  // R11
  glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_q |-> $past(glob_q));
  // R10
  pulse_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_q && |(rise_i & en_q)) |=> serr_q);
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_log_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int ROW_W  = 16,
  parameter int BANK_W = 3,
  parameter int RANK_W = 2,
  parameter int SYN_W  = 8,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrok_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_multi,
  input  logic [COL_W-1:0]  ev_col,
  input  logic [ROW_W-1:0]  ev_row,
  input  logic [BANK_W-1:0] ev_bank,
  input  logic [RANK_W-1:0] ev_rank,
  input  logic [SYN_W-1:0]  ev_synd,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              serr_o
);
  localparam int NF = NUM_FLAGS;

  logic          ev_fire;
  logic [NF-1:0] set_v, clr_v, flag_v, rise_v, en_v;
  logic          glob_v;
  logic          wr_stat, wr_ecmd, wr_gcmd;
  logic [COL_W-1:0]  l_col;
  logic [ROW_W-1:0]  l_row;
  logic [BANK_W-1:0] l_bank;
  logic [RANK_W-1:0] l_rank;
  logic [SYN_W-1:0]  l_synd;

  assign ev_ready = 1'b1;
  assign ev_fire  = ev_valid;

  assign set_v[FLAG_SBE] = ev_fire && !ev_multi;
  assign set_v[FLAG_MBE] = ev_fire &&  ev_multi;

  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_ecmd = reg_wr && (reg_addr == A_ECMD);
  assign wr_gcmd = reg_wr && (reg_addr == A_GCMD);
  assign clr_v   = wr_stat ? reg_wdata[NF-1:0] : '0;

  ecc_err_flags #(.NF(NF)) u_flags (
    .clk     (clk),
    .pwrok_n (pwrok_n),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .flag_o  (flag_v),
    .rise_o  (rise_v)
  );

  ecc_err_log #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .RANK_W(RANK_W), .SYN_W(SYN_W)
  ) u_log (
    .clk      (clk),
    .pwrok_n  (pwrok_n),
    .ev_fire  (ev_fire),
    .ev_multi (ev_multi),
    .ev_col   (ev_col),
    .ev_row   (ev_row),
    .ev_bank  (ev_bank),
    .ev_rank  (ev_rank),
    .ev_synd  (ev_synd),
    .sflag_i  (flag_v[FLAG_SBE]),
    .mflag_i  (flag_v[FLAG_MBE]),
    .log_col  (l_col),
    .log_row  (l_row),
    .log_bank (l_bank),
    .log_rank (l_rank),
    .log_synd (l_synd)
  );

  ecc_serr_gen #(.NF(NF)) u_serr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ecmd    (wr_ecmd),
    .wr_gcmd    (wr_gcmd),
    .en_wdata   (reg_wdata[NF-1:0]),
    .glob_wdata (reg_wdata[0]),
    .rise_i     (rise_v),
    .en_o       (en_v),
    .glob_o     (glob_v),
    .serr_o     (serr_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:  reg_rdata = DW'(flag_v);
      A_ECMD:  reg_rdata = DW'(en_v);
      A_GCMD:  reg_rdata = DW'(glob_v);
      A_LCOL:  reg_rdata = DW'(l_col);
      A_LROW:  reg_rdata = DW'(l_row);
      A_LBR:   reg_rdata = DW'({l_rank, l_bank});
      A_LSYN:  reg_rdata = DW'(l_synd);
      default: reg_rdata = '0;
    endcase
  end

  // R1
  sbe_source_chk: assert property (@(posedge clk) disable iff (!pwrok_n)
    $rose(flag_v[FLAG_SBE]) |-> $past(ev_valid && !ev_multi));
  // R1
  mbe_source_chk: assert property (@(posedge clk) disable iff (!pwrok_n)
    $rose(flag_v[FLAG_MBE]) |-> $past(ev_valid && ev_multi));
endmodule

// File: tb/test_ecc_err_status.sv
`timescale 1ns/1ps
module test_ecc_err_status;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, pwrok_n = 1'b0;
  logic        ev_valid = 1'b0, ev_multi = 1'b0;
  logic        ev_ready;
  logic [9:0]  ev_col = '0;
  logic [15:0] ev_row = '0;
  logic [2:0]  ev_bank = '0;
  logic [1:0]  ev_rank = '0;
  logic [7:0]  ev_synd = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        serr_o;

  ecc_err_status i_ecc_err_status (
    .clk(clk), .rst_n(rst_n), .pwrok_n(pwrok_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_multi(ev_multi),
    .ev_col(ev_col), .ev_row(ev_row), .ev_bank(ev_bank), .ev_rank(ev_rank), .ev_synd(ev_synd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .serr_o(serr_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_s, m_m, m_ens, m_enm, m_glob, m_serr;
  int m_col, m_row, m_bank, m_rank, m_synd;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset_pg();
    m_s = 0; m_m = 0; m_col = 0; m_row = 0; m_bank = 0; m_rank = 0; m_synd = 0;
  endtask

  // One clock: compute the expected next state from the driven inputs,
  // cross the edge, then compare the message output.
  task automatic cyc(input string req);
    int ns, nm, ne_s, ne_m, ng, nserr;
    ns = m_s; nm = m_m; ne_s = m_ens; ne_m = m_enm; ng = m_glob;
    if (reg_wr && reg_addr == 0) begin
      if (reg_wdata[0]) ns = 0;
      if (reg_wdata[1]) nm = 0;
    end
    if (ev_valid) begin
      if (ev_multi) nm = 1; else ns = 1;
      if (m_m == 0 && (ev_multi || m_s == 0)) begin
        m_col = ev_col; m_row = ev_row; m_bank = ev_bank; m_rank = ev_rank; m_synd = ev_synd;
      end
    end
    nserr = (m_glob != 0) && ((nm == 1 && m_m == 0 && m_enm != 0) ||
                              (ns == 1 && m_s == 0 && m_ens != 0));
    if (reg_wr && reg_addr == 1) begin ne_s = reg_wdata[0]; ne_m = reg_wdata[1]; end
    if (reg_wr && reg_addr == 2) ng = reg_wdata[0];
    m_s = ns; m_m = nm; m_ens = ne_s; m_enm = ne_m; m_glob = ng; m_serr = nserr;
    if (!rst_n) begin m_ens = 0; m_enm = 0; m_glob = 0; m_serr = 0; end
    if (!pwrok_n) model_reset_pg();
    @(posedge clk);
    #1;
    check(serr_o == m_serr, {req, "/R10 serr"}, serr_o, m_serr);
    check(ev_ready == 1'b1, "R12 ready", ev_ready, 1);
  endtask

  function automatic int exp_reg(input int a);
    case (a)
      0: return m_s | (m_m << 1);
      1: return m_ens | (m_enm << 1);
      2: return m_glob;
      3: return m_col;
      4: return m_row;
      5: return m_bank | (m_rank << 3);
      6: return m_synd;
      default: return 0;
    endcase
  endfunction

  task automatic readall(input string req);
    reg_wr = 0; ev_valid = 0;
    for (int a = 0; a < 7; a++) begin
      reg_addr = 3'(a);
      #0.1;
      check(int'(reg_rdata) == exp_reg(a), req, int'(reg_rdata), exp_reg(a));
    end
  endtask

  task automatic idle();
    reg_wr = 0; ev_valid = 0;
  endtask

  task automatic wreg(input int a, input int d, input string req);
    idle(); reg_wr = 1; reg_addr = 3'(a); reg_wdata = 16'(d);
    cyc(req);
    idle();
  endtask

  task automatic event_in(input bit mul, input int c, input int r, input int b,
                          input int k, input int s, input string req);
    idle(); ev_valid = 1; ev_multi = mul;
    ev_col = 10'(c); ev_row = 16'(r); ev_bank = 3'(b); ev_rank = 2'(k); ev_synd = 8'(s);
    cyc(req);
    idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ens = 0; m_enm = 0; m_glob = 0; m_serr = 0;
    model_reset_pg();
    repeat (3) cyc("reset");
    rst_n = 1; pwrok_n = 1;
    cyc("reset");
    readall("R1 R13 reset values");

    wreg(1, 3, "R10 enable");
    wreg(2, 1, "R10 global");
    readall("R13 command readback");

    event_in(0, 5, 1234, 2, 1, 8'h3c, "R6 sbe capture");
    readall("R6 log after first sbe");
    event_in(0, 9, 777, 5, 3, 8'h11, "R7 sbe locked");
    readall("R7 log unchanged");

    event_in(1, 321, 4242, 6, 2, 8'hA5, "R8 mbe overwrite");
    readall("R8 log after mbe");
    event_in(1, 1, 2, 3, 0, 8'h01, "R9 mbe frozen");
    event_in(0, 2, 3, 4, 1, 8'h02, "R9 sbe frozen");
    readall("R9 frozen log");

    wreg(0, 0, "R2 write zero");
    readall("R2 no effect");
    wreg(0, 2, "R2 clear multi");
    readall("R2 multi cleared");
    wreg(0, 1, "R2 clear single");
    readall("R2 single cleared");

    event_in(0, 44, 55, 1, 1, 8'h66, "R6 capture unlocked");
    idle(); reg_wr = 1; reg_addr = 0; reg_wdata = 16'h1;
    ev_valid = 1; ev_multi = 0; ev_col = 10'd7;
    cyc("R5 event beats clear");
    idle();
    readall("R5 flag kept");

    rst_n = 0; cyc("R3 ordinary reset"); cyc("R3 ordinary reset");
    rst_n = 1; cyc("R3 ordinary reset");
    readall("R3 R13 flags kept cmd cleared");

    wreg(0, 3, "R11 clear all");
    wreg(1, 3, "R11 enables");
    event_in(0, 1, 1, 1, 1, 1, "R11 global off no pulse");
    event_in(0, 2, 2, 2, 2, 2, "R11 level no pulse");
    wreg(2, 1, "R11 global on");
    event_in(0, 3, 3, 3, 3, 3, "R11 already set");
    wreg(1, 1, "R11 mask mbe");
    event_in(1, 9, 9, 1, 1, 9, "R11 masked mbe");
    readall("R11 state");

    pwrok_n = 0; rst_n = 0; cyc("R3 power-good reset");
    pwrok_n = 1; rst_n = 1; cyc("R3 power-good reset");
    readall("R3 power-good cleared");

    wreg(1, 3, "R12 enable");
    wreg(2, 1, "R12 global");
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      ev_valid = (r < 60);
      ev_multi = ($urandom_range(0, 4) == 0);
      ev_col = 10'($urandom); ev_row = 16'($urandom); ev_bank = 3'($urandom);
      ev_rank = 2'($urandom); ev_synd = 8'($urandom);
      reg_wr = ($urandom_range(0, 5) == 0);
      reg_addr = 3'($urandom_range(0, 2));
      reg_wdata = 16'($urandom_range(0, 3));
      cyc("R12 stream");
      if (i % 8 == 7) readall("R4 R8 R9 stream regs");
    end
    idle();
    cyc("end");
    readall("final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule